// File: doc/BRIEF.md
# Exception Vectoring and Interrupt Arbiter

This block decides, each cycle, whether the core must leave its current instruction stream for firmware. Four asynchronous interrupt lines (device, timer, inter-processor, machine check) are filtered against the current 3-bit priority level and the privileged-mode bit. A synchronous exception request carries a cause code and, for trap calls, an 8-bit call code. When something is taken, the block computes the firmware entry address as the firmware base register plus a fixed per-cause offset. It returns that address together with the address to resume at, and it signals the switch into privileged mode.

The exception request is a valid/ready stream. `exc_ready` is low only in the cycle in which `ent_taken` is high. A request with `exc_valid` high in that cycle is not consumed and must be held by the requester. Back-pressure is never applied for more than one cycle. The interrupt lines, priority level, mode bit, PC and base are plain level inputs, and they are sampled on the same edge as an accepted request. The entry outputs are registered. `ent_taken` is a one-cycle pulse, and `ent_pc` and `ent_saved` are meaningful while it is high.

Top module: `exc_vector_arb`

## Requirements
- R1: While `cur_priv` is 1, no interrupt is taken, whatever the interrupt lines and priority level are. Exceptions are still accepted.
- R2: An interrupt line is eligible only at certain levels of `cur_ipl`. Device is eligible at levels 0..3, timer at 0..4, inter-processor at 0..5 and machine check at 0..6. At level 7 none is eligible.
- R3: Among eligible pending interrupts the winner is machine check, then inter-processor, then timer, then device.
- R4: Each interrupt has a fixed entry offset: machine check 0x080, inter-processor 0x100, timer 0x180, device 0x200.
- R5: `exc_cause` encodes the exception kind. The codes are 0 reset (0x000), 1 machine check (0x080), 2 inter-processor (0x100), 3 timer (0x180), 4 device (0x200), 5 memory fault (0x280), 6 unaligned (0x300), 7 illegal opcode (0x380), 8 arithmetic (0x400) and 9 floating-point disabled (0x480). Codes 11..15 are reserved and vector like illegal opcode (0x380).
- R6: Cause 10 is a trap call. If bit 7 of `exc_code` is 1 the offset is 0x2000 + (code − 0x80)·64. Otherwise it is 0x1000 + code·64.
- R7: On entry `ent_saved` equals `cur_pc` with bit 0 replaced by `cur_pc[0] | cur_priv`, both sampled at the accepting edge.
- R8: On entry `ent_pc` equals `fw_base` + offset and `ent_priv` is 1.
- R9: When an exception is accepted in the same cycle as an eligible interrupt, the exception is the one vectored.
- R10: Outputs appear one clock after the accepting edge. `ent_taken` is never high two cycles in a row. In its cycle `exc_ready` is 0 and all requests, interrupt or exception, are ignored.
- R11: After reset `ent_taken` and `ent_priv` are 0 and `exc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_dev | input | 1 | Device interrupt request level |
| irq_tmr | input | 1 | Timer interrupt request level |
| irq_ipi | input | 1 | Inter-processor interrupt request level |
| irq_mchk | input | 1 | Machine-check interrupt request level |
| exc_valid | input | 1 | Synchronous exception request valid |
| exc_ready | output | 1 | Exception request can be accepted |
| exc_cause | input | 4 | Exception cause code (R5/R6) |
| exc_code | input | 8 | Trap-call code, used for cause 10 |
| cur_pc | input | 64 | Current program counter |
| cur_priv | input | 1 | Current privileged-mode bit |
| cur_ipl | input | 3 | Current interrupt priority level |
| fw_base | input | 64 | Firmware base address |
| ent_taken | output | 1 | One-cycle entry pulse |
| ent_pc | output | 64 | Firmware entry address |
| ent_saved | output | 64 | Saved resume address with mode in bit 0 |
| ent_priv | output | 1 | New mode bit |

## Verification
Single interrupt lines are driven at each priority level, with the boundary levels 3/4, 4/5, 5/6 and 6/7 chosen so that an off-by-one mask is exposed. Combinations of pending lines then separate the winner order from the masking. The same lines are repeated with the privileged bit set, which tells a mode block apart from a level mask. Every exception cause, including a reserved one, is sent with trap codes at both ends of both tables. Collisions of an exception with an interrupt, and requests held through the pulse cycle, show precedence and the ignored busy cycle. Odd and even PCs in both modes tell the saved mode bit apart from a plain copy of the PC.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam int CAUSE_W = 4;
  localparam int NSRC    = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CS_RESET    = 4'd0,
    CS_MCHK     = 4'd1,
    CS_IPI      = 4'd2,
    CS_TIMER    = 4'd3,
    CS_DEVICE   = 4'd4,
    CS_MEMFLT   = 4'd5,
    CS_UNALIGN  = 4'd6,
    CS_ILLEGAL  = 4'd7,
    CS_ARITH    = 4'd8,
    CS_FPOFF    = 4'd9,
    CS_TRAPCALL = 4'd10
  } cause_e;

  // Interrupt source index: higher index wins arbitration.
  localparam int SRC_DEV  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_IPI  = 2;
  localparam int SRC_MCHK = 3;

  // Highest priority level at which a source is still eligible.
  function automatic int src_ceiling(int idx);
    return 3 + idx;
  endfunction

  function automatic cause_e src_cause(int idx);
    case (idx)
      SRC_DEV: return CS_DEVICE;
      SRC_TMR: return CS_TIMER;
      SRC_IPI: return CS_IPI;
      default: return CS_MCHK;
    endcase
  endfunction

endpackage

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import exc_vec_pkg::*;
#(
  parameter int IPL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [IPL_W-1:0] ipl,
  input  logic             priv,
  output logic [NSRC-1:0]  grant,
  output logic             pick_valid,
  output cause_e           pick_cause
);

  logic [NSRC-1:0] level_open;
  logic [NSRC-1:0] eligible;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int LIM = src_ceiling(g);
    assign level_open[g] = (32'(ipl) <= LIM);
    assign eligible[g]   = irq_req[g] & level_open[g] & ~priv;
  end

  // Later (higher-index) sources overwrite earlier ones: fall-through priority.
  always_comb begin
    grant      = '0;
    pick_cause = CS_RESET;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i]) begin
        grant      = '0;
        grant[i]   = 1'b1;
        pick_cause = src_cause(i);
      end
    end
  end

  assign pick_valid = |grant;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_PRIV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    priv |-> (grant == '0)); // R1
  AST_DEV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    grant[SRC_DEV] |-> (32'(ipl) <= 3)); // R2
  AST_MCHK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[SRC_MCHK] && !priv && 32'(ipl) <= 6) |-> grant[SRC_MCHK]); // R3

endmodule

// File: rtl/entry_offset_calc.sv
module entry_offset_calc
  import exc_vec_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int OFF_W       = 14,
  parameter int VEC_SLOT_LG = 7,
  parameter int TRAP_SLOT_LG = 6
) (
  input  cause_e             cause,
  input  logic [CODE_W-1:0]  code,
  output logic [OFF_W-1:0]   offset
);

  localparam logic [OFF_W-1:0] TRAP_PRIV_BASE   = OFF_W'(1) << (OFF_W - 2);
  localparam logic [OFF_W-1:0] TRAP_UNPRIV_BASE = OFF_W'(1) << (OFF_W - 1);

  logic [CAUSE_W-1:0] cause_v;
  logic [OFF_W-1:0]   trap_base;
  logic [OFF_W-1:0]   trap_slot;

  assign cause_v   = cause;
  assign trap_base = code[CODE_W-1] ? TRAP_UNPRIV_BASE : TRAP_PRIV_BASE;
  assign trap_slot = OFF_W'(code[CODE_W-2:0]) << TRAP_SLOT_LG;

  always_comb begin
    if (cause == CS_TRAPCALL) begin
      offset = trap_base + trap_slot;
    end else if (cause_v <= CAUSE_W'(CS_FPOFF)) begin
      offset = OFF_W'(cause_v) << VEC_SLOT_LG;
    end else begin
      offset = OFF_W'(CS_ILLEGAL) << VEC_SLOT_LG;
    end
  end

endmodule

// File: rtl/vec_entry_reg.sv
module vec_entry_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [XLEN-1:0] new_pc,
  input  logic [XLEN-1:0] new_saved,
  output logic            taken_q,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] saved_q,
  output logic            priv_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      pc_q    <= '0;
      saved_q <= '0;
      priv_q  <= 1'b0;
    end else begin
      taken_q <= take;
      if (take) begin
        pc_q    <= new_pc;
        saved_q <= new_saved;
        priv_q  <= 1'b1;
      end
    end
  end

  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |=> !taken_q); // R10
  AST_ENTRY_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q |-> priv_q); // R8

endmodule

// File: rtl/exc_vector_arb.sv
module exc_vector_arb
  import exc_vec_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IPL_W  = 3,
  parameter int CODE_W = 8,
  parameter int OFF_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_dev,
  input  logic              irq_tmr,
  input  logic              irq_ipi,
  input  logic              irq_mchk,
  input  logic              exc_valid,
  output logic              exc_ready,
  input  logic [3:0]        exc_cause,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              cur_priv,
  input  logic [IPL_W-1:0]  cur_ipl,
  input  logic [XLEN-1:0]   fw_base,
  output logic              ent_taken,
  output logic [XLEN-1:0]   ent_pc,
  output logic [XLEN-1:0]   ent_saved,
  output logic              ent_priv
);

  logic [NSRC-1:0]   irq_vec;
  logic [NSRC-1:0]   grant;
  logic              pick_valid;
  cause_e            pick_cause;
  logic              exc_fire;
  logic              irq_go;
  logic              take;
  cause_e            sel_cause;
  logic [CODE_W-1:0] sel_code;
  logic [OFF_W-1:0]  offset;
  logic [XLEN-1:0]   new_pc;
  logic [XLEN-1:0]   new_saved;

  always_comb begin
    irq_vec           = '0;
    irq_vec[SRC_DEV]  = irq_dev;
    irq_vec[SRC_TMR]  = irq_tmr;
    irq_vec[SRC_IPI]  = irq_ipi;
    irq_vec[SRC_MCHK] = irq_mchk;
  end

  irq_level_arb #(.IPL_W(IPL_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_vec),
    .ipl        (cur_ipl),
    .priv       (cur_priv),
    .grant      (grant),
    .pick_valid (pick_valid),
    .pick_cause (pick_cause)
  );

  // Busy for exactly the cycle the entry pulse is visible.
  assign exc_ready = ~ent_taken;
  assign exc_fire  = exc_valid & exc_ready;
  assign irq_go    = pick_valid & ~ent_taken;
  assign take      = exc_fire | irq_go;

  assign sel_cause = exc_fire ? cause_e'(exc_cause) : pick_cause;
  assign sel_code  = exc_fire ? exc_code : '0;

  entry_offset_calc #(.CODE_W(CODE_W), .OFF_W(OFF_W)) u_off (
    .cause  (sel_cause),
    .code   (sel_code),
    .offset (offset)
  );

  assign new_pc    = fw_base + XLEN'(offset);
  assign new_saved = {cur_pc[XLEN-1:1], cur_pc[0] | cur_priv};

  vec_entry_reg #(.XLEN(XLEN)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .new_pc    (new_pc),
    .new_saved (new_saved),
    .taken_q   (ent_taken),
    .pc_q      (ent_pc),
    .saved_q   (ent_saved),
    .priv_q    (ent_priv)
  );

  AST_SAVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ent_taken |-> (ent_saved[0] == ($past(cur_pc[0]) | $past(cur_priv)))); // R7
  AST_IRQ_NOT_IN_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_taken && !$past(exc_valid && exc_ready)) |-> !$past(cur_priv)); // R1
  AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_ready) |=> ent_taken); // R10
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    ent_taken |-> !exc_ready); // R10

endmodule

// File: tb/tb_exc_vector_arb.sv
module tb_exc_vector_arb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_dev = 0, irq_tmr = 0, irq_ipi = 0, irq_mchk = 0;
  logic        exc_valid = 0;
  logic        exc_ready;
  logic [3:0]  exc_cause = '0;
  logic [7:0]  exc_code = '0;
  logic [63:0] cur_pc = '0;
  logic        cur_priv = 0;
  logic [2:0]  cur_ipl = '0;
  logic [63:0] fw_base = '0;
  logic        ent_taken;
  logic [63:0] ent_pc;
  logic [63:0] ent_saved;
  logic        ent_priv;

  always #4 clk = ~clk;  // 125 MHz

  exc_vector_arb dut (
    .clk(clk), .rst_n(rst_n),
    .irq_dev(irq_dev), .irq_tmr(irq_tmr), .irq_ipi(irq_ipi), .irq_mchk(irq_mchk),
    .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_cause(exc_cause),
    .exc_code(exc_code), .cur_pc(cur_pc), .cur_priv(cur_priv), .cur_ipl(cur_ipl),
    .fw_base(fw_base), .ent_taken(ent_taken), .ent_pc(ent_pc),
    .ent_saved(ent_saved), .ent_priv(ent_priv)
  );

  typedef struct {
    bit          take;
    logic [63:0] pc;
    logic [63:0] saved;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit prev_take = 0;
  bit done = 0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] cause_off(int c, logic [7:0] code);
    case (c)
      0: return 64'h000;  1: return 64'h080;  2: return 64'h100;
      3: return 64'h180;  4: return 64'h200;  5: return 64'h280;
      6: return 64'h300;  7: return 64'h380;  8: return 64'h400;
      9: return 64'h480;
      10: return code[7] ? 64'h2000 + 64'(code - 8'h80) * 64
                         : 64'h1000 + 64'(code) * 64;
      default: return 64'h380;
    endcase
  endfunction

  // irq bits: [0] device, [1] timer, [2] inter-processor, [3] machine check
  task automatic step(input logic [3:0] irq, input int ipl, input bit priv,
                      input bit ev, input int cause, input logic [7:0] code,
                      input logic [63:0] pc, input logic [63:0] base,
                      input string tag);
    exp_t e;
    bit busy;
    bit efire;
    int win;
    @(negedge clk);
    irq_dev = irq[0]; irq_tmr = irq[1]; irq_ipi = irq[2]; irq_mchk = irq[3];
    cur_ipl = 3'(ipl); cur_priv = priv; exc_valid = ev;
    exc_cause = 4'(cause); exc_code = code; cur_pc = pc; fw_base = base;
    busy = prev_take;
    efire = ev && !busy;
    win = -1;
    if (!priv && !busy) begin
      if (irq[0] && ipl <= 3) win = 4;
      if (irq[1] && ipl <= 4) win = 3;
      if (irq[2] && ipl <= 5) win = 2;
      if (irq[3] && ipl <= 6) win = 1;
    end
    e.tag = tag;
    e.take = efire || (win >= 0);
    e.saved = {pc[63:1], pc[0] | priv};
    e.pc = base + (efire ? cause_off(cause, code) : cause_off(win, 8'h00));
    q.push_back(e);
    prev_take = e.take;
    #1;
    check(exc_ready == !busy, "R10 exc_ready", 64'(exc_ready), 64'(!busy));
  endtask

  task automatic idle();
    step(4'b0000, 0, 0, 0, 0, 8'h00, 64'h0, 64'h0, "R10 idle");
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(ent_taken == e.take, {e.tag, " taken"}, 64'(ent_taken), 64'(e.take));
        if (e.take) begin
          check(ent_pc == e.pc, {e.tag, " R8 entry pc"}, ent_pc, e.pc);
          check(ent_saved == e.saved, {e.tag, " R7 saved"}, ent_saved, e.saved);
          check(ent_priv == 1'b1, {e.tag, " R8 mode"}, 64'(ent_priv), 64'h1);
        end
      end else if (ent_taken) begin
        check(1'b0, "R10 unexpected entry", 64'h1, 64'h0);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] b;
    b = 64'h0000_0000_4000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check(ent_taken == 0, "R11 taken", 64'(ent_taken), 64'h0);
    check(ent_priv == 0, "R11 mode", 64'(ent_priv), 64'h0);
    check(exc_ready == 1, "R11 ready", 64'(exc_ready), 64'h1);

    // R4 single interrupts at level 0
    step(4'b0001, 0, 0, 0, 0, 0, 64'h1000, b, "R4 device"); idle();
    step(4'b0010, 0, 0, 0, 0, 0, 64'h1004, b, "R4 timer"); idle();
    step(4'b0100, 0, 0, 0, 0, 0, 64'h1008, b, "R4 ipi"); idle();
    step(4'b1000, 0, 0, 0, 0, 0, 64'h100C, b, "R4 mchk"); idle();

    // R2 level boundaries
    step(4'b0001, 3, 0, 0, 0, 0, 64'h2000, b, "R2 dev ipl3"); idle();
    step(4'b0001, 4, 0, 0, 0, 0, 64'h2000, b, "R2 dev ipl4");
    step(4'b0010, 4, 0, 0, 0, 0, 64'h2004, b, "R2 tmr ipl4"); idle();
    step(4'b0010, 5, 0, 0, 0, 0, 64'h2004, b, "R2 tmr ipl5");
    step(4'b0100, 5, 0, 0, 0, 0, 64'h2008, b, "R2 ipi ipl5"); idle();
    step(4'b0100, 6, 0, 0, 0, 0, 64'h2008, b, "R2 ipi ipl6");
    step(4'b1000, 6, 0, 0, 0, 0, 64'h200C, b, "R2 mchk ipl6"); idle();
    step(4'b1111, 7, 0, 0, 0, 0, 64'h200C, b, "R2 all ipl7");

    // R3 priority
    step(4'b1111, 0, 0, 0, 0, 0, 64'h3000, b, "R3 all"); idle();
    step(4'b0111, 2, 0, 0, 0, 0, 64'h3004, b, "R3 ipi over tmr"); idle();
    step(4'b0011, 1, 0, 0, 0, 0, 64'h3008, b, "R3 tmr over dev"); idle();
    step(4'b0111, 5, 0, 0, 0, 0, 64'h300C, b, "R3 masked mix"); idle();

    // R1 privileged mode blocks interrupts but not exceptions
    step(4'b1111, 0, 1, 0, 0, 0, 64'h4000, b, "R1 priv irq");
    step(4'b1000, 6, 1, 0, 0, 0, 64'h4000, b, "R1 priv mchk");
    step(4'b1111, 0, 1, 1, 5, 0, 64'h4010, b, "R1 priv exc"); idle();

    // R5 every cause plus reserved codes
    for (int c = 0; c < 10; c++) begin
      step(4'b0000, 0, 0, 1, c, 8'h00, 64'h5000 + 64'(c * 4), b + 64'h10_0000, "R5 cause");
      idle();
    end
    step(4'b0000, 0, 0, 1, 11, 8'h00, 64'h5101, b, "R5 reserved11"); idle();
    step(4'b0000, 0, 0, 1, 15, 8'h00, 64'h5104, b, "R5 reserved15"); idle();

    // R6 trap-call tables
    step(4'b0000, 0, 0, 1, 10, 8'h00, 64'h6000, b, "R6 priv first"); idle();
    step(4'b0000, 0, 0, 1, 10, 8'h3F, 64'h6004, b, "R6 priv 3f"); idle();
    step(4'b0000, 0, 0, 1, 10, 8'h7F, 64'h6008, b, "R6 priv last"); idle();
    step(4'b0000, 0, 1, 1, 10, 8'h80, 64'h600C, b, "R6 unpriv first"); idle();
    step(4'b0000, 0, 0, 1, 10, 8'h83, 64'h6010, b, "R6 unpriv 83"); idle();
    step(4'b0000, 0, 0, 1, 10, 8'hFF, 64'h6014, b, "R6 unpriv last"); idle();

    // R7 odd PC and mode bit combinations
    step(4'b0000, 0, 0, 1, 8, 0, 64'hFFFF_0000_0000_7001, b, "R7 odd user"); idle();
    step(4'b0000, 0, 1, 1, 8, 0, 64'hFFFF_0000_0000_7000, b, "R7 even priv"); idle();

    // R9 exception beats interrupt
    step(4'b1111, 0, 0, 1, 6, 0, 64'h8000, b, "R9 exc vs irq"); idle();
    step(4'b1000, 0, 0, 1, 10, 8'h81, 64'h8004, b, "R9 trap vs mchk"); idle();

    // R10 held requests are ignored during the pulse cycle
    step(4'b0000, 0, 0, 1, 9, 0, 64'h9000, b, "R10 held exc 1");
    step(4'b0000, 0, 0, 1, 9, 0, 64'h9000, b, "R10 held exc busy");
    step(4'b0000, 0, 0, 1, 9, 0, 64'h9000, b, "R10 held exc 2");
    step(4'b0010, 0, 0, 0, 0, 0, 64'h9100, b, "R10 held irq busy");
    step(4'b0010, 0, 0, 0, 0, 0, 64'h9104, b, "R10 held irq 2");
    idle(); idle();

    repeat (3) @(posedge clk);
    #4;
    check(q.size() == 0, "R10 scoreboard drained", 64'(q.size()), 64'h0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule